// File: doc/BRIEF.md
# Dual Instruction-Address Breakpoint Request Unit

This block watches the stream of instructions the CPU is about to start and raises an interrupt request on the cycle an instruction begins, before that instruction runs, if its 20-bit address equals one of two programmable match addresses. Each of the two match channels has its own enable bit. The request goes straight to the interrupt controller along with the index of the channel that fired. The global interrupt enable flag and the processor priority level do not gate it. This makes it usable for breakpoints and for patching code held in read-only memory.

Software sets the block up through a small synchronous byte-wide register port. One enable byte holds a bit per channel. Each channel's match address is spread over three consecutive bytes: low, middle, and a top byte whose low nibble carries address bits 19:16. Vectoring, stacking of the program counter and the CPU pipeline belong to other blocks.

Top module: `brkpt_match_unit`

## Requirements
- R1: After reset both enable bits are 0, every match-address bit is 0, and no request is raised.
- R2: The enable byte is at register address 0x09. Bit 0 enables channel 0 and bit 1 enables channel 1 (1 = enabled). Bits 7:2 ignore writes and read as 0.
- R3: Channel 0's match address occupies register bytes 0x10 (bits 7:0), 0x11 (bits 15:8) and 0x12 (bits 19:16 in data bits 3:0). Channel 1 uses 0x14, 0x15 and 0x16 in the same way. Data bits 7:4 of each top byte ignore writes and read as 0, and any value from 0x00000 to 0xFFFFF can be held.
- R4: On a cycle with `fetch_valid` high, if `fetch_addr` equals the match address of an enabled channel, `brk_req` is high in that same cycle and `brk_chan` gives the channel index (0 or 1).
- R5: `brk_req` is never high on a cycle where `fetch_valid` is low.
- R6: A channel whose enable bit is 0 never produces a request, even when the address matches.
- R7: When both enabled channels match the same address, one request is issued and `brk_chan` is 0. `brk_chan` reads 0 whenever `brk_req` is low.
- R8: A register write takes effect from the next clock cycle. A comparison made in the same cycle as the write uses the old value.
- R9: The comparison covers all 20 address bits. An address that differs from the match address in any single bit produces no request.
- R10: `reg_rdata` is 0 when `reg_sel` is low or when the address is not one of the seven mapped bytes. Writes to unmapped addresses, and writes made with `reg_sel` low, change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register port select |
| reg_we | input | 1 | Write enable, qualified by reg_sel |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| fetch_valid | input | 1 | Instruction-start strobe |
| fetch_addr | input | 20 | Address of the instruction about to start |
| brk_req | output | 1 | Single-cycle breakpoint request |
| brk_chan | output | 1 | Index of the requesting channel |

## Verification
The hardest case to reach is a register write landing in the same cycle as a comparison that depends on it. The bench drives a write to a match byte and an instruction-start strobe at the old address together, checks that the request still fires, and then probes the new address on the next cycle. Near-miss addresses are covered by a walk of every single-bit flip of the match address. Register decoding is covered by sweeping all 256 register addresses for both reads and writes.

// File: rtl/brkpt_pkg.sv
`timescale 1ns/1ps
package brkpt_pkg;
   localparam int unsigned BRK_ADDR_W    = 20;
   localparam int unsigned BRK_NUM_CH    = 2;
   localparam int unsigned BRK_BUS_AW    = 8;
   localparam int unsigned BRK_DATA_W    = 8;
   localparam int unsigned BRK_EN_LOC    = 'h09;
   localparam int unsigned BRK_CH_BASE   = 'h10;
   localparam int unsigned BRK_CH_STRIDE = 4;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/brkpt_regfile.sv
`timescale 1ns/1ps
module brkpt_regfile #(
   parameter int unsigned ADDR_W    = brkpt_pkg::BRK_ADDR_W,
   parameter int unsigned NUM_CH    = brkpt_pkg::BRK_NUM_CH,
   parameter int unsigned BUS_AW    = brkpt_pkg::BRK_BUS_AW,
   parameter int unsigned DATA_W    = brkpt_pkg::BRK_DATA_W,
   parameter int unsigned EN_LOC    = brkpt_pkg::BRK_EN_LOC,
   parameter int unsigned CH_BASE   = brkpt_pkg::BRK_CH_BASE,
   parameter int unsigned CH_STRIDE = brkpt_pkg::BRK_CH_STRIDE
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          reg_sel,
   input  logic                          reg_we,
   input  logic [BUS_AW-1:0]             reg_addr,
   input  logic [DATA_W-1:0]             reg_wdata,
   output logic [DATA_W-1:0]             reg_rdata,
   output logic [NUM_CH-1:0]             ch_en,
   output logic [NUM_CH-1:0][ADDR_W-1:0] ch_match
);
   localparam int unsigned NBYTES = (ADDR_W + DATA_W - 1) / DATA_W;

   if (NUM_CH > DATA_W) begin : g_bad_enable_width
      $error("enable byte too narrow for channel count");
   end
   if (NBYTES > CH_STRIDE) begin : g_bad_stride
      $error("channel register stride smaller than address byte count");
   end
   if (ADDR_W < 1 || NUM_CH < 1) begin : g_bad_size
      $error("address width and channel count must be positive");
   end

   function automatic logic [BUS_AW-1:0] byte_loc(input int unsigned c, input int unsigned b);
      return BUS_AW'(CH_BASE + c * CH_STRIDE + b);
   endfunction

   function automatic logic [DATA_W-1:0] byte_mask(input int unsigned b);
      logic [DATA_W-1:0] m;
      for (int unsigned i = 0; i < DATA_W; i++) begin
         m[i] = ((b * DATA_W + i) < ADDR_W);
      end
      return m;
   endfunction

   logic              wr_stb;
   logic [NUM_CH-1:0] en_q;
   logic [DATA_W-1:0] byte_q [NUM_CH][NBYTES];

   assign wr_stb = reg_sel & reg_we;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
         for (int unsigned c = 0; c < NUM_CH; c++) begin
            for (int unsigned b = 0; b < NBYTES; b++) begin
               byte_q[c][b] <= '0;
            end
         end
      end else if (wr_stb) begin
         if (reg_addr == BUS_AW'(EN_LOC)) begin
            en_q <= reg_wdata[NUM_CH-1:0];
         end
         for (int unsigned c = 0; c < NUM_CH; c++) begin
            for (int unsigned b = 0; b < NBYTES; b++) begin
               if (reg_addr == byte_loc(c, b)) begin
                  byte_q[c][b] <= reg_wdata & byte_mask(b);
               end
            end
         end
      end
   end

   always_comb begin
      for (int unsigned c = 0; c < NUM_CH; c++) begin
         for (int unsigned i = 0; i < ADDR_W; i++) begin
            ch_match[c][i] = byte_q[c][i / DATA_W][i % DATA_W];
         end
      end
   end

   assign ch_en = en_q;

   always_comb begin
      reg_rdata = '0;
      if (reg_sel) begin
         if (reg_addr == BUS_AW'(EN_LOC)) begin
            reg_rdata[NUM_CH-1:0] = en_q;
         end
         for (int unsigned c = 0; c < NUM_CH; c++) begin
            for (int unsigned b = 0; b < NBYTES; b++) begin
               if (reg_addr == byte_loc(c, b)) begin
                  reg_rdata = byte_q[c][b];
               end
            end
         end
      end
   end

   assert_en_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_sel && reg_we && reg_addr == BUS_AW'(EN_LOC)) |=> $stable(en_q));
   assert_idle_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_sel |-> reg_rdata == '0);
   assert_top_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel && reg_addr == byte_loc(0, NBYTES - 1))
         |-> (reg_rdata & ~byte_mask(NBYTES - 1)) == '0);
endmodule

// File: rtl/brkpt_comparator.sv
`timescale 1ns/1ps
module brkpt_comparator #(
   parameter int unsigned ADDR_W = brkpt_pkg::BRK_ADDR_W
) (
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              ch_en,
   input  logic [ADDR_W-1:0] ch_match,
   output logic              hit
);
   assign hit = fetch_valid & ch_en & (fetch_addr == ch_match);
endmodule

// File: rtl/brkpt_prio_pick.sv
`timescale 1ns/1ps
module brkpt_prio_pick #(
   parameter int unsigned N         = brkpt_pkg::BRK_NUM_CH,
   parameter int unsigned IDX_W     = brkpt_pkg::idx_width(N),
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   assign any = |req;

   if (LOW_FIRST) begin : g_low_first
      always_comb begin
         idx = '0;
         for (int i = int'(N) - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
         end
      end
   end else begin : g_high_first
      always_comb begin
         idx = '0;
         for (int i = 0; i < int'(N); i++) begin
            if (req[i]) idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/brkpt_match_unit.sv
`timescale 1ns/1ps
module brkpt_match_unit #(
   parameter int unsigned ADDR_W    = brkpt_pkg::BRK_ADDR_W,
   parameter int unsigned NUM_CH    = brkpt_pkg::BRK_NUM_CH,
   parameter int unsigned BUS_AW    = brkpt_pkg::BRK_BUS_AW,
   parameter int unsigned DATA_W    = brkpt_pkg::BRK_DATA_W,
   parameter int unsigned EN_LOC    = brkpt_pkg::BRK_EN_LOC,
   parameter int unsigned CH_BASE   = brkpt_pkg::BRK_CH_BASE,
   parameter int unsigned CH_STRIDE = brkpt_pkg::BRK_CH_STRIDE,
   parameter bit          LOW_FIRST = 1'b1,
   localparam int unsigned IDX_W    = brkpt_pkg::idx_width(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_we,
   input  logic [BUS_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              brk_req,
   output logic [IDX_W-1:0]  brk_chan
);
   logic [NUM_CH-1:0]             ch_en;
   logic [NUM_CH-1:0][ADDR_W-1:0] ch_match;
   logic [NUM_CH-1:0]             ch_hit;

   brkpt_regfile #(
      .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .BUS_AW(BUS_AW), .DATA_W(DATA_W),
      .EN_LOC(EN_LOC), .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ch_en(ch_en), .ch_match(ch_match)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
      brkpt_comparator #(.ADDR_W(ADDR_W)) u_cmp (
         .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
         .ch_en(ch_en[c]), .ch_match(ch_match[c]), .hit(ch_hit[c])
      );
   end

   brkpt_prio_pick #(.N(NUM_CH), .IDX_W(IDX_W), .LOW_FIRST(LOW_FIRST)) u_pick (
      .req(ch_hit), .any(brk_req), .idx(brk_chan)
   );

   assert_strobe_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req |-> fetch_valid);
   assert_enabled_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req |-> ch_en[brk_chan]);
   assert_addr_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req |-> fetch_addr == ch_match[brk_chan]);
   assert_idle_chan_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !brk_req |-> brk_chan == '0);
   if (LOW_FIRST) begin : g_prio_chk
      assert_low_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
         ch_hit[0] |-> (brk_req && brk_chan == '0));
   end
endmodule

// File: tb/test_brkpt_match_unit.sv
`timescale 1ns/1ps
module test_brkpt_match_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_sel = 1'b0, reg_we = 1'b0;
   logic [7:0]  reg_addr = '0, reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        fetch_valid = 1'b0;
   logic [19:0] fetch_addr = '0;
   logic        brk_req;
   logic        brk_chan;

   int n_checks = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   brkpt_match_unit i_brkpt_match_unit (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
      .brk_req(brk_req), .brk_chan(brk_chan)
   );

   // shadow of the programmed state
   logic [1:0]  m_en = '0;
   logic [19:0] m_addr [2] = '{default: '0};

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(input logic [7:0] a);
      case (a)
         8'h09: return {6'b0, m_en};
         8'h10: return m_addr[0][7:0];
         8'h11: return m_addr[0][15:8];
         8'h12: return {4'b0, m_addr[0][19:16]};
         8'h14: return m_addr[1][7:0];
         8'h15: return m_addr[1][15:8];
         8'h16: return {4'b0, m_addr[1][19:16]};
         default: return 8'h00;
      endcase
   endfunction

   function automatic bit is_mapped(input logic [7:0] a);
      return a == 8'h09 || a == 8'h10 || a == 8'h11 || a == 8'h12 ||
             a == 8'h14 || a == 8'h15 || a == 8'h16;
   endfunction

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_sel = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_sel = 0; reg_we = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_sel = 1; reg_we = 0; reg_addr = a;
      #1 d = reg_rdata;
      reg_sel = 0;
   endtask

   task automatic set_match(input int ch, input logic [19:0] v);
      wr(8'(8'h10 + 4 * ch), v[7:0]);
      wr(8'(8'h11 + 4 * ch), v[15:8]);
      wr(8'(8'h12 + 4 * ch), {4'hF, v[19:16]});
      m_addr[ch] = v;
   endtask

   task automatic set_en(input logic [1:0] e);
      wr(8'h09, {6'b111111, e});
      m_en = e;
   endtask

   function automatic logic [1:0] exp_brk(input logic v, input logic [19:0] a);
      if (!v) return 2'b00;
      if (m_en[0] && a == m_addr[0]) return 2'b10;
      if (m_en[1] && a == m_addr[1]) return 2'b11;
      return 2'b00;
   endfunction

   task automatic probe(input string tag, input logic v, input logic [19:0] a);
      @(negedge clk);
      fetch_valid = v; fetch_addr = a;
      #1 check(tag, {brk_req, brk_chan}, exp_brk(v, a));
      fetch_valid = 0;
   endtask

   task automatic sweep_reads(input string tag);
      logic [7:0] d;
      for (int a = 0; a < 256; a++) begin
         rd(8'(a), d);
         check(tag, d, exp_read(8'(a)));
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up();
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      // R1 reset state: outputs and every register byte
      #1 check("R1 no request in reset", {brk_req, brk_chan}, 2'b00);
      rst_n = 1;
      sweep_reads("R1 R10 reset read sweep");
      probe("R1 zero address not enabled", 1'b1, 20'h00000);

      // R2 R3 write all ones everywhere, then compare every address
      for (int a = 0; a < 256; a++) wr(8'(a), 8'hFF);
      m_en = 2'b11; m_addr[0] = 20'hFFFFF; m_addr[1] = 20'hFFFFF;
      sweep_reads("R2 R3 all-ones read sweep");
      probe("R3 R4 max address match", 1'b1, 20'hFFFFF);

      // R10 writes to unmapped addresses and with select low change nothing
      for (int a = 0; a < 256; a++) if (!is_mapped(8'(a))) wr(8'(a), 8'h00);
      @(negedge clk);
      reg_sel = 0; reg_we = 1; reg_addr = 8'h10; reg_wdata = 8'h00;
      @(negedge clk);
      reg_we = 0;
      sweep_reads("R10 unmapped and deselected writes ignored");

      // R3 R4 distinct addresses per channel
      set_match(0, 20'h12345);
      set_match(1, 20'hABCDE);
      set_en(2'b11);
      rd(8'h12, d); check("R3 ch0 top byte", d, 8'h01);
      rd(8'h16, d); check("R3 ch1 top byte", d, 8'h0A);
      probe("R4 ch0 hit", 1'b1, 20'h12345);
      probe("R4 ch1 hit", 1'b1, 20'hABCDE);
      probe("R4 unrelated address", 1'b1, 20'h54321);
      // R5 strobe low
      probe("R5 strobe low ch0", 1'b0, 20'h12345);
      probe("R5 strobe low ch1", 1'b0, 20'hABCDE);

      // R9 every single-bit neighbour of both match addresses
      for (int b = 0; b < 20; b++) begin
         probe("R9 ch0 bit flip", 1'b1, 20'h12345 ^ (20'h1 << b));
         probe("R9 ch1 bit flip", 1'b1, 20'hABCDE ^ (20'h1 << b));
      end

      // R6 each enable pattern against both addresses
      for (int e = 0; e < 4; e++) begin
         set_en(2'(e));
         probe("R6 enable gating ch0", 1'b1, 20'h12345);
         probe("R6 enable gating ch1", 1'b1, 20'hABCDE);
      end

      // R7 both channels on one address
      set_match(1, 20'h12345);
      set_en(2'b11);
      probe("R7 both match picks ch0", 1'b1, 20'h12345);
      set_en(2'b10);
      probe("R7 ch1 alone on shared address", 1'b1, 20'h12345);
      set_en(2'b11);

      // R8 write and compare in the same cycle
      set_match(1, 20'hABCDE);
      @(negedge clk);
      reg_sel = 1; reg_we = 1; reg_addr = 8'h10; reg_wdata = 8'h46;
      fetch_valid = 1; fetch_addr = 20'h12345;
      #1 check("R8 old value used in write cycle", {brk_req, brk_chan}, 2'b10);
      @(negedge clk);
      reg_sel = 0; reg_we = 0;
      m_addr[0] = 20'h12346;
      #1 check("R8 old value gone next cycle", {brk_req, brk_chan}, 2'b00);
      fetch_valid = 0;
      probe("R8 new value matches", 1'b1, 20'h12346);

      // R4 zero address boundary
      set_match(0, 20'h00000);
      probe("R4 zero address match", 1'b1, 20'h00000);

      // R1 reset again clears everything
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1;
      m_en = '0; m_addr[0] = '0; m_addr[1] = '0;
      sweep_reads("R1 second reset read sweep");
      probe("R1 no request after reset", 1'b1, 20'h00000);

      finish_up();
   end
endmodule